// File: doc/BRIEF.md
# Masked-Lane Sample Unpacker

This block sits between a DMA stream and a digital-to-analog converter datapath. Each incoming 64-bit word holds four 16-bit lanes. A lane-valid mask travels with every word. The block slices each word into sample sets, one set per output cycle. A set is one, two or four lanes wide, chosen by the number of enabled channels. Lanes the mask marks as padding are dropped, so a short block whose last word is only partly filled never puts zero samples on the converter side.

A second word register is filled while the current word is still being emitted. Because of that prefetch, the end of one word or block runs straight into the start of the next with no idle cycle. This also holds for a stream of blocks that each carry a single sample set. When the output wants data while a block is still open and no sample is buffered, an underflow flag is raised for that cycle.

Top module: `sample_unpacker`

## Requirements
- R1: After reset `out_valid` and `underflow` are low and `in_ready` is high.
- R2: Lane i of a word is `in_data[16*i +: 16]`. The sets of a word are emitted starting at the lowest lanes. Each set occupies the low lanes of `out_data`, and all lanes above the set width read zero.
- R3: `chan_mode` sets the set width: 0 gives one lane, 1 gives two lanes, and 2 or 3 give four lanes.
- R4: `in_lanes` bit i marks lane i as valid. Masks are contiguous from lane 0, and only the last word of a block may have a mask other than all ones. A word yields (valid lanes / set width) sets, and padding lanes never appear on `out_data`.
- R5: The next word is buffered while the current one plays out. With input data available and `out_ready` high, one set leaves per cycle across word and block boundaries, including back-to-back single-set blocks.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: `out_last` is high exactly on the final set of a word accepted with `in_last` high.
- R8: `underflow` is high in a cycle where `out_ready` is high, `out_valid` is low, and a block has started whose last word has not yet been accepted. In every other cycle it is low, including the idle time between blocks.
- R9: `in_ready` is high whenever the prefetch register is free or is freed in that cycle, so it is always high while `out_valid` is low. A word accepted into an empty block appears on `out_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_mode | input | 2 | Set width select (R3) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 64 | Four packed 16-bit lanes |
| in_lanes | input | 4 | Lane-valid mask |
| in_last | input | 1 | Word ends a block |
| out_valid | output | 1 | Sample set valid |
| out_ready | input | 1 | Converter side takes a set |
| out_data | output | 64 | Sample set in low lanes, upper lanes zero |
| out_last | output | 1 | Final set of a block |
| underflow | output | 1 | Starved in the middle of a block |

## Verification
The assertions assume a well-formed DMA side: every mask is non-empty and contiguous from lane 0, and only words flagged `in_last` carry a partial mask. A presented word stays unchanged until it is accepted, and the valid-lane count is a multiple of the set width. The stimulus builds every block from a set count and the current width, so these rules always hold. It changes `chan_mode` only once both the send queue and the output are drained. Padding lanes are filled with non-zero marker values, so any padding lane that reaches `out_data` is detected. Input gaps are inserted only through the valid gate, never by dropping a presented word.

// File: rtl/sample_unpacker.sv
module sample_unpacker #(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 4,
  localparam int WORD_W  = SAMPLE_W * LANES,
  localparam int LOG_L   = $clog2(LANES),
  localparam int MODE_W  = $clog2(LOG_L + 1),
  localparam int CNT_W   = LOG_L + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] chan_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LANES-1:0]  in_lanes,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              underflow
);

  logic [WORD_W-1:0] d0, d1;
  logic [CNT_W-1:0]  c0, c1, off, ss, in_cnt;
  logic              v0, v1, l0, l1, open_blk;
  logic [MODE_W-1:0] mode_c;
  logic              last_set, fire, pop, acc, to_slot1;
  logic [WORD_W-1:0] shifted;

  assign mode_c   = (int'(chan_mode) > LOG_L) ? MODE_W'(LOG_L) : chan_mode;
  assign ss       = CNT_W'(1) << mode_c;
  assign in_cnt   = CNT_W'($countones(in_lanes));
  assign last_set = (int'(off) + int'(ss)) >= int'(c0);
  assign fire     = v0 & out_ready;
  assign pop      = fire & last_set;
  assign in_ready = ~v1 | pop;
  assign acc      = in_valid & in_ready;
  assign to_slot1 = pop ? v1 : v0;

  assign out_valid = v0;
  assign out_last  = v0 & l0 & last_set;
  assign underflow = out_ready & ~v0 & open_blk;
  assign shifted   = d0 >> (SAMPLE_W * int'(off));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign out_data[i*SAMPLE_W +: SAMPLE_W] =
      (i < int'(ss)) ? shifted[i*SAMPLE_W +: SAMPLE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0;  v1 <= 1'b0;
      l0 <= 1'b0;  l1 <= 1'b0;
      d0 <= '0;    d1 <= '0;
      c0 <= '0;    c1 <= '0;
      off <= '0;
      open_blk <= 1'b0;
    end else begin
      if (fire) off <= pop ? '0 : off + ss;
      if (pop) begin
        v0 <= v1; d0 <= d1; c0 <= c1; l0 <= l1;
        v1 <= 1'b0;
      end
      if (acc) begin
        if (to_slot1) begin
          v1 <= 1'b1; d1 <= in_data; c1 <= in_cnt; l1 <= in_last;
        end else begin
          v0 <= 1'b1; d0 <= in_data; c0 <= in_cnt; l0 <= in_last;
        end
        open_blk <= ~in_last;
      end
    end
  end

endmodule

// File: rtl/sample_unpacker_chk.sv
module sample_unpacker_chk #(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 4,
  localparam int WORD_W  = SAMPLE_W * LANES,
  localparam int MODE_W  = $clog2($clog2(LANES) + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] chan_mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic [LANES-1:0]  in_lanes,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last,
  input logic              underflow
);

  a_r4_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_lanes != '0) && ((in_lanes & (in_lanes + 1'b1)) == '0));

  a_r4_partial_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |-> (&in_lanes));

  a_r9_input_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> in_valid && $stable(in_data) && $stable(in_lanes) && $stable(in_last));

  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_underflow_starved: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> out_ready && !out_valid);

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_single_lane_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && chan_mode == '0) |-> (out_data[WORD_W-1:SAMPLE_W] == '0));

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

bind sample_unpacker sample_unpacker_chk chk_i (.*);

// File: tb/sample_unpacker_test.sv
module sample_unpacker_test;

  typedef struct { logic [63:0] d; logic [3:0] m; logic last; } word_t;
  typedef struct { logic [63:0] d; logic last; logic eow; } set_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chan_mode = 2'd2;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  in_lanes = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_last;
  logic        underflow;

  sample_unpacker uut (.*);

  always #10 clk = ~clk;

  word_t sendq[$];
  set_t  pend[$];
  int    checks = 0, fails = 0, cyc = 0;
  int    vrate = 100, rrate = 100, cur_ss = 4;
  bit    hold = 0, open_blk = 0, in_reset = 1;
  bit    prev_stall = 0;
  logic [63:0] prev_data;
  logic  s_uf;
  int    first_fire = -1, last_fire = -1, nfire = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%h expected=%h", req, what, cyc, act, exp);
    end
  endtask

  task automatic add_block(int nsets);
    int lanes = nsets * cur_ss;
    while (lanes > 0) begin
      word_t w;
      int n = (lanes > 4) ? 4 : lanes;
      for (int i = 0; i < 4; i++)
        w.d[i*16 +: 16] = (i < n) ? 16'($urandom) : 16'hBAD0 + 16'(i);
      w.m = 4'((1 << n) - 1);
      lanes -= n;
      w.last = (lanes == 0);
      sendq.push_back(w);
    end
  endtask

  task automatic push_sets(word_t w);
    int cnt = $countones(w.m);
    int ns = cnt / cur_ss;
    for (int j = 0; j < ns; j++) begin
      set_t s;
      s.d = '0;
      for (int k = 0; k < cur_ss; k++) s.d[k*16 +: 16] = w.d[(j*cur_ss + k)*16 +: 16];
      s.eow = (j == ns - 1);
      s.last = w.last && s.eow;
      pend.push_back(s);
    end
  endtask

  task automatic step();
    bit ev, fire, pop, acc, exp_rdy, exp_uf;
    int words = 0;
    @(negedge clk);
    if (!hold) in_valid = (sendq.size() > 0) && ($urandom_range(99) < vrate);
    if (in_valid) begin
      in_data = sendq[0].d; in_lanes = sendq[0].m; in_last = sendq[0].last;
    end
    out_ready = ($urandom_range(99) < rrate);
    #5;
    ev = pend.size() > 0;
    foreach (pend[i]) if (pend[i].eow) words++;
    fire = out_ready && ev;
    pop = fire && pend[0].eow;
    exp_rdy = (words < 2) || pop;
    exp_uf = out_ready && !ev && open_blk;
    chk("R5", "out_valid", 64'(out_valid), 64'(ev));
    chk("R9", "in_ready", 64'(in_ready), 64'(exp_rdy));
    chk("R8", "underflow", 64'(underflow), 64'(exp_uf));
    if (ev && out_valid) begin
      chk("R2 R3 R4", "out_data", out_data, pend[0].d);
      chk("R7", "out_last", 64'(out_last), 64'(pend[0].last));
    end
    if (prev_stall) chk("R6", "held data", out_data, prev_data);
    prev_stall = out_valid && !out_ready;
    prev_data = out_data;
    s_uf = underflow;
    if (fire) begin
      if (first_fire < 0) first_fire = cyc;
      last_fire = cyc;
      nfire++;
      void'(pend.pop_front());
    end
    acc = in_valid && in_ready;
    if (acc) begin
      push_sets(sendq[0]);
      open_blk = !sendq[0].last;
      void'(sendq.pop_front());
    end
    hold = in_valid && !acc;
    cyc++;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sendq.size() > 0 || pend.size() > 0 || hold) && guard < 5000) begin
      step();
      guard++;
    end
  endtask

  task automatic set_mode(int m);
    @(negedge clk);
    chan_mode = 2'(m);
    cur_ss = (m == 0) ? 1 : (m == 1) ? 2 : 4;
  endtask

  task automatic span_check(string what);
    chk("R5", what, 64'(last_fire - first_fire + 1), 64'(nfire));
    first_fire = -1; last_fire = -1; nfire = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "in_ready", 64'(in_ready), 64'd1);
    chk("R1", "underflow", 64'(underflow), 64'd0);

    // full-width sets, gapless stream of blocks
    set_mode(2);
    vrate = 100; rrate = 100;
    add_block(3); add_block(1); add_block(1); add_block(2);
    drain();
    span_check("four-lane span");

    // two lanes: odd set counts leave a half-filled last word
    set_mode(1);
    add_block(3); add_block(1); add_block(5);
    for (int b = 0; b < 6; b++) add_block(1);
    drain();
    span_check("two-lane single-set blocks span");

    // one lane with random gaps on both sides
    set_mode(0);
    vrate = 60; rrate = 55;
    for (int b = 0; b < 40; b++) add_block(1 + $urandom_range(6));
    drain();
    for (int b = 0; b < 6; b++) add_block(1);
    vrate = 100; rrate = 100;
    first_fire = -1; nfire = 0;
    drain();
    span_check("one-lane single-set blocks span");

    // mode 3 behaves as four lanes
    set_mode(3);
    vrate = 70; rrate = 70;
    for (int b = 0; b < 20; b++) add_block(1 + $urandom_range(3));
    drain();

    // two lanes under heavy back-pressure
    set_mode(1);
    vrate = 90; rrate = 30;
    for (int b = 0; b < 30; b++) add_block(1 + $urandom_range(5));
    drain();

    // starvation in the middle of a block
    set_mode(2);
    vrate = 100; rrate = 100;
    add_block(3);
    step();
    vrate = 0;
    step();
    step();
    chk("R8", "mid-block starve", 64'(s_uf), 64'd1);
    vrate = 100;
    drain();
    step();
    chk("R8", "idle after block", 64'(s_uf), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule